// File: doc/BRIEF.md
# Dual-Tone Channel Sample Generator

This block produces one 16-bit sample per channel on every sample-clock enable, for the digital side of a DAC datapath. Every channel owns two sine generators. Each generator has three settings of its own: a frequency tuning word, a phase offset and a signed gain. A per-channel source code chooses what reaches the output: the saturated sum of the two scaled tones, a sample taken from an external stream input, or a free-running 16-bit ramp. Codes that name none of these three give silence.

Settings arrive through a single-cycle write port. The write port addresses a channel and one of five registers in that channel. Tone settings go into shadow storage first. A global sync strobe copies them into the working registers of every channel in the same cycle. The same strobe clears all phase accumulators, so that all channels start again phase-aligned.

A core-run control holds the whole sample path in reset while it is low. Register writes and sync still take effect during that time. A tone-path-absent input forces the tone source to zero.

Top module: `dds_chan_gen`

## Requirements
- R1: While the source code is 0, each tone's 16-bit phase accumulator starts at 0 after a sync and adds the 16-bit tuning word (register 0 or 1, bits 15:0) once per enabled sample. The tone output for sample n (counted from 0 after a sync) uses the phase address p = (n·F + P) mod 65536. The top 10 bits of p select one of 1024 steps, and the tone value approximates 32767·sin(2π·(step+0.5)/1024) to within ±60 LSB, before gain.
- R2: Bits 31:16 of the same tuning register hold the phase offset P. Offsets 0 to 65535 map linearly onto 0 to 2π, so an offset of 0x4000 shifts the tone by a quarter period.
- R3: Each tone's gain (register 2 for tone A, register 3 for tone B, bits 15:0) is sign-magnitude. Bit 15 negates the tone. Bits 14:0 are the magnitude with 14 fraction bits, so 0x4000 is unity, 0x2000 is one half, and 0xC000 is minus one.
- R4: The two scaled tones are added, and the sum is clamped to the range −32768 to 32767 rather than wrapping.
- R5: The 4-bit source code in register 4, bits 3:0, takes effect on the next write and needs no sync. Code 0 selects the tones, code 2 the channel's external sample, and code 11 the ramp. Every other code outputs 0.
- R6: Each channel's ramp counts the enabled samples since the core-run control rose. The ramp output is 0, 1, 2 and so on, and it wraps from 0xFFFF to 0.
- R7: Writes to tuning and gain registers do not change the output until a sync strobe. The strobe loads every channel's new settings in the same cycle and restarts all tone accumulators at 0.
- R8: While core-run is low, the sample outputs and the valid flag are 0 and the accumulators and ramps are cleared. Writes and sync issued during that time are kept, and they apply once core-run returns high.
- R9: While the tone-path-absent input is high, source code 0 outputs 0. The stream and ramp sources are not affected.
- R10: The valid output is high exactly in the cycle after an edge at which the sample enable was high. The sample outputs change only on such edges.
- R11: Writes address one channel only, and the other channels keep their settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| core_run | input | 1 | Low holds the sample path in reset |
| dds_absent | input | 1 | High forces the tone source to zero |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_reg | input | 3 | Register: 0/1 tuning A/B, 2/3 gain A/B, 4 source code |
| cfg_wdata | input | 32 | Write data |
| sync_strobe | input | 1 | Loads shadow settings and realigns accumulators |
| smp_en | input | 1 | Sample-clock enable |
| ext_smp | input | NUM_CH*16 | External stream samples, channel 0 in the low bits |
| smp_out | output | NUM_CH*16 | Output samples, channel 0 in the low bits |
| smp_valid | output | 1 | New samples present on smp_out |

## Verification
The tone path is driven from a table of settings. The table covers a single unity tone, the same tone shifted a quarter period, a negated tone, two half-gain tones at different rates, two near-double-gain tones in phase, and a tone at half the sample rate. Each setting is compared against a floating-point sine reference. Together these separate errors in the accumulator step, in the position of the phase field, in the gain sign and magnitude, and in clamping versus wrap-around. Directed sequences then interleave unsynced writes, sync, source codes, the tone-absent input and core-run hold, so that deferral, isolation between channels and realignment are each visible at the outputs. A run of 65536 samples brings the ramp across its wrap point.

// File: rtl/dds_pkg.sv
package dds_pkg;
   localparam int SMP_W = 16;
   localparam int PH_W  = 16;
   localparam int GAIN_FRAC = 14;

   typedef logic [3:0] src_code_t;
   localparam src_code_t SRC_TONES  = 4'd0;
   localparam src_code_t SRC_STREAM = 4'd2;
   localparam src_code_t SRC_RAMP   = 4'd11;

   typedef enum logic [2:0] {
      REG_TUNE_A = 3'd0,
      REG_TUNE_B = 3'd1,
      REG_GAIN_A = 3'd2,
      REG_GAIN_B = 3'd3,
      REG_SRC    = 3'd4
   } reg_sel_e;

   typedef struct packed {
      logic [PH_W-1:0] phase;
      logic [PH_W-1:0] freq;
   } tune_t;
endpackage

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
   import dds_pkg::*;
#(
   parameter int LUT_AW = 8
) (
   input  logic [LUT_AW+1:0]      phase_q,
   output logic signed [SMP_W-1:0] sine
);
   localparam int    QDEPTH = 1 << LUT_AW;
   localparam longint HALF  = 4 * QDEPTH;

   // rational sine approximation evaluated at the midpoint of each step
   function automatic logic [14:0] entry(input int i);
      longint x, p, v;
      x = 2 * i + 1;
      p = x * (HALF - x);
      v = (32767 * 4 * p) / ((5 * HALF * HALF) / 4 - p);
      return v[14:0];
   endfunction

   logic [14:0] qtab [QDEPTH];
   for (genvar gi = 0; gi < QDEPTH; gi++) begin : g_tab
      assign qtab[gi] = entry(gi);
   end

   logic [LUT_AW-1:0] idx;
   logic [14:0]       mag;

   always_comb begin
      idx  = phase_q[LUT_AW] ? ~phase_q[LUT_AW-1:0] : phase_q[LUT_AW-1:0];
      mag  = qtab[idx];
      sine = phase_q[LUT_AW+1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
   end
endmodule

// File: rtl/dds_tone.sv
module dds_tone
   import dds_pkg::*;
#(
   parameter int LUT_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              adv,
   input  logic              restart,
   input  tune_t             tune,
   input  logic [15:0]       gain,
   output logic signed [17:0] scaled
);
   localparam int QW = LUT_AW + 2;

   logic [PH_W-1:0]         acc_q;
   logic [PH_W-1:0]         paddr;
   logic signed [SMP_W-1:0] sine;
   logic signed [31:0]      prod;
   logic signed [17:0]      mag18;
   logic                    unused_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc_q <= '0;
      else if (!run)    acc_q <= '0;
      else if (restart) acc_q <= '0;
      else if (adv)     acc_q <= acc_q + tune.freq;
   end

   assign paddr = acc_q + tune.phase;

   dds_sine_rom #(.LUT_AW(LUT_AW)) rom_i (
      .phase_q (paddr[PH_W-1 -: QW]),
      .sine    (sine)
   );

   always_comb begin
      prod   = 32'(sine) * 32'({17'b0, gain[14:0]});
      mag18  = prod[31:GAIN_FRAC];
      scaled = gain[15] ? -mag18 : mag18;
   end

   assign unused_bits = ^{paddr, prod[GAIN_FRAC-1:0]};
endmodule

// File: rtl/dds_chan.sv
module dds_chan
   import dds_pkg::*;
#(
   parameter int LUT_AW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             smp_en,
   input  logic             sync,
   input  logic             wr_en,
   input  logic [2:0]       wr_reg,
   input  logic [31:0]      wr_data,
   input  logic             dds_absent,
   input  logic [SMP_W-1:0] ext_smp,
   output logic [SMP_W-1:0] smp_out,
   output src_code_t        src_sel
);
   localparam int NTONE = 2;

   tune_t       sh_tune  [NTONE];
   tune_t       act_tune [NTONE];
   logic [15:0] sh_gain  [NTONE];
   logic [15:0] act_gain [NTONE];
   src_code_t   src_q;

   logic signed [17:0]      tone_val [NTONE];
   logic signed [18:0]      mix_sum;
   logic signed [SMP_W-1:0] mix_sat;
   logic [SMP_W-1:0]        tone_mix;
   logic [SMP_W-1:0]        ramp_q;
   logic [SMP_W-1:0]        next_smp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < NTONE; t++) begin
            sh_tune[t]  <= '0;
            act_tune[t] <= '0;
            sh_gain[t]  <= '0;
            act_gain[t] <= '0;
         end
         src_q <= SRC_TONES;
      end else begin
         if (wr_en) begin
            case (reg_sel_e'(wr_reg))
               REG_TUNE_A: sh_tune[0] <= wr_data;
               REG_TUNE_B: sh_tune[1] <= wr_data;
               REG_GAIN_A: sh_gain[0] <= wr_data[15:0];
               REG_GAIN_B: sh_gain[1] <= wr_data[15:0];
               REG_SRC:    src_q      <= wr_data[3:0];
               default: ;
            endcase
         end
         if (sync) begin
            act_tune <= sh_tune;
            act_gain <= sh_gain;
         end
      end
   end

   for (genvar t = 0; t < NTONE; t++) begin : g_tone
      dds_tone #(.LUT_AW(LUT_AW)) tone_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .run     (run),
         .adv     (smp_en),
         .restart (sync),
         .tune    (act_tune[t]),
         .gain    (act_gain[t]),
         .scaled  (tone_val[t])
      );
   end

   always_comb begin
      mix_sum = $signed({tone_val[0][17], tone_val[0]})
              + $signed({tone_val[1][17], tone_val[1]});
      if (mix_sum > 19'sd32767)       mix_sat = 16'sh7FFF;
      else if (mix_sum < -19'sd32768) mix_sat = 16'sh8000;
      else                            mix_sat = mix_sum[15:0];
      tone_mix = dds_absent ? '0 : mix_sat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ramp_q <= '0;
      else if (!run)   ramp_q <= '0;
      else if (smp_en) ramp_q <= ramp_q + 1'b1;
   end

   always_comb begin
      case (src_q)
         SRC_TONES:  next_smp = tone_mix;
         SRC_STREAM: next_smp = ext_smp;
         SRC_RAMP:   next_smp = ramp_q;
         default:    next_smp = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      smp_out <= '0;
      else if (!run)   smp_out <= '0;
      else if (smp_en) smp_out <= next_smp;
   end

   assign src_sel = src_q;
endmodule

// File: rtl/dds_chan_gen.sv
module dds_chan_gen
   import dds_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int LUT_AW = 8,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    core_run,
   input  logic                    dds_absent,
   input  logic                    cfg_we,
   input  logic [CH_W-1:0]         cfg_ch,
   input  logic [2:0]              cfg_reg,
   input  logic [31:0]             cfg_wdata,
   input  logic                    sync_strobe,
   input  logic                    smp_en,
   input  logic [NUM_CH*SMP_W-1:0] ext_smp,
   output logic [NUM_CH*SMP_W-1:0] smp_out,
   output logic                    smp_valid
);
   if (NUM_CH < 1) begin : g_bad_num_ch
      $error("dds_chan_gen: NUM_CH must be at least 1");
   end
   if (LUT_AW < 2 || LUT_AW > PH_W - 2) begin : g_bad_lut_aw
      $error("dds_chan_gen: LUT_AW must lie in 2..14");
   end

   logic [NUM_CH*4-1:0] src_sel_all;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dds_chan #(.LUT_AW(LUT_AW)) chan_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .run        (core_run),
         .smp_en     (smp_en),
         .sync       (sync_strobe),
         .wr_en      (cfg_we && (cfg_ch == CH_W'(c))),
         .wr_reg     (cfg_reg),
         .wr_data    (cfg_wdata),
         .dds_absent (dds_absent),
         .ext_smp    (ext_smp[c*SMP_W +: SMP_W]),
         .smp_out    (smp_out[c*SMP_W +: SMP_W]),
         .src_sel    (src_sel_all[c*4 +: 4])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        smp_valid <= 1'b0;
      else if (!core_run) smp_valid <= 1'b0;
      else               smp_valid <= smp_en;
   end
endmodule

// File: rtl/dds_chan_gen_chk.sv
module dds_chan_gen_chk #(
   parameter int NUM_CH = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 core_run,
   input logic                 dds_absent,
   input logic                 smp_en,
   input logic [NUM_CH*16-1:0] smp_out,
   input logic                 smp_valid,
   input logic [NUM_CH*4-1:0]  src_sel_all
);
   // R10: valid follows an enabled edge
   p_valid_follows_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && core_run) |=> smp_valid);

   // R10: no valid without an enable
   p_idle_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |=> !smp_valid);

   // R10: outputs hold between enables
   p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_en && core_run) |=> $stable(smp_out));

   // R8: core hold clears outputs
   p_hold_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !core_run |=> (smp_out == '0) && !smp_valid);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // R5: unknown source codes give silence
      p_quiet_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (smp_en && core_run && !(src_sel_all[c*4 +: 4] inside {4'd0, 4'd2, 4'd11}))
         |=> (smp_out[c*16 +: 16] == 16'd0));

      // R9: tone source silent when the tone path is absent
      p_absent_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (smp_en && core_run && dds_absent && src_sel_all[c*4 +: 4] == 4'd0)
         |=> (smp_out[c*16 +: 16] == 16'd0));
   end
endmodule

bind dds_chan_gen dds_chan_gen_chk #(.NUM_CH(NUM_CH)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .core_run    (core_run),
   .dds_absent  (dds_absent),
   .smp_en      (smp_en),
   .smp_out     (smp_out),
   .smp_valid   (smp_valid),
   .src_sel_all (src_sel_all)
);

// File: tb/dds_chan_gen_tb_top.sv
`timescale 1ns/1ps
module dds_chan_gen_tb_top;
   localparam int NCH = 2;
   localparam int TOL = 300;
   localparam int NVEC = 6;
   // {fwA, phA, gainA, fwB, phB, gainB}
   localparam logic [95:0] VEC [NVEC] = '{
      {16'h0400, 16'h0000, 16'h4000, 16'h0000, 16'h0000, 16'h0000},
      {16'h0400, 16'h4000, 16'h4000, 16'h0000, 16'h0000, 16'h0000},
      {16'h0400, 16'h0000, 16'hC000, 16'h0000, 16'h0000, 16'h0000},
      {16'h0400, 16'h0000, 16'h2000, 16'h1000, 16'h2000, 16'h2000},
      {16'h0800, 16'h0000, 16'h7FFF, 16'h0800, 16'h0000, 16'h7FFF},
      {16'h8000, 16'h1000, 16'h4000, 16'h0000, 16'h0000, 16'h0000}
   };
   localparam string VTAG [NVEC] = '{"R1", "R2", "R3", "R4", "R4", "R1"};

   logic clk = 1'b0, rst_n = 1'b0, core_run = 1'b0, dds_absent = 1'b0;
   logic cfg_we = 1'b0, sync_strobe = 1'b0, smp_en = 1'b0;
   logic [0:0]  cfg_ch = '0;
   logic [2:0]  cfg_reg = '0;
   logic [31:0] cfg_wdata = '0;
   logic [NCH*16-1:0] ext_smp = '0;
   logic [NCH*16-1:0] smp_out;
   logic smp_valid;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dds_chan_gen #(.NUM_CH(NCH), .LUT_AW(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .core_run(core_run), .dds_absent(dds_absent),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
      .sync_strobe(sync_strobe), .smp_en(smp_en), .ext_smp(ext_smp),
      .smp_out(smp_out), .smp_valid(smp_valid)
   );

   task automatic check(string req, int act, int exp, int tol);
      n_chk++;
      if (act > exp + tol || act < exp - tol) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int tone_ref(int fw, int ph, int g, int n);
      int p, q;
      real s, k;
      p = (n * fw + ph) & 32'hFFFF;
      q = p >> 6;
      s = $sin(6.283185307179586 * (q + 0.5) / 1024.0) * 32767.0;
      k = real'(g & 32'h7FFF) / 16384.0;
      if ((g & 32'h8000) != 0) k = -k;
      return $rtoi(s * k);
   endfunction

   function automatic int mix_ref(logic [95:0] v, int n);
      int s;
      s = tone_ref(v[95:80], v[79:64], v[63:48], n) + tone_ref(v[47:32], v[31:16], v[15:0], n);
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      return s;
   endfunction

   function automatic int ch_s(int c);
      return $signed(smp_out[c*16 +: 16]);
   endfunction

   function automatic int ch_u(int c);
      return int'(smp_out[c*16 +: 16]);
   endfunction

   task automatic wr(int ch, int r, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 1'(ch); cfg_reg = 3'(r); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic prog(int ch, logic [95:0] v);
      wr(ch, 0, {v[79:64], v[95:80]});
      wr(ch, 1, {v[31:16], v[47:32]});
      wr(ch, 2, {16'h0, v[63:48]});
      wr(ch, 3, {16'h0, v[15:0]});
   endtask

   task automatic sync_pulse();
      @(negedge clk); sync_strobe = 1'b1;
      @(negedge clk); sync_strobe = 1'b0;
   endtask

   task automatic step();
      @(negedge clk); smp_en = 1'b1;
      @(negedge clk); smp_en = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [95:0] nv;
      int a;
      repeat (4) @(negedge clk);
      check("R8 reset output", ch_u(0) + ch_u(1), 0, 0);
      check("R8 reset valid", int'(smp_valid), 0, 0);
      rst_n = 1'b1;
      core_run = 1'b1;

      // R10 valid pulse and hold
      @(negedge clk); smp_en = 1'b1;
      @(negedge clk); smp_en = 1'b0;
      check("R10 valid after enable", int'(smp_valid), 1, 0);
      a = ch_u(0);
      @(negedge clk);
      check("R10 valid drops", int'(smp_valid), 0, 0);
      check("R10 output held", ch_u(0), a, 0);

      // table of tone settings on channel 0
      for (int v = 0; v < NVEC; v++) begin
         prog(0, VEC[v]);
         wr(0, 4, 32'd0);
         sync_pulse();
         for (int n = 0; n < 12; n++) begin
            step();
            check($sformatf("%s vector %0d sample %0d", VTAG[v], v, n), ch_s(0), mix_ref(VEC[v], n), TOL);
         end
      end

      // R7: writes deferred until sync, sync restarts accumulators
      prog(0, VEC[0]);
      sync_pulse();
      for (int n = 0; n < 3; n++) begin
         step();
         check("R7 baseline", ch_s(0), mix_ref(VEC[0], n), TOL);
      end
      wr(0, 0, {16'h0000, 16'h2000});
      step();
      check("R7 tuning deferred", ch_s(0), mix_ref(VEC[0], 3), TOL);
      wr(0, 2, 32'h0000C000);
      step();
      check("R7 gain deferred", ch_s(0), mix_ref(VEC[0], 4), TOL);
      sync_pulse();
      nv = {16'h2000, 16'h0000, 16'hC000, 48'h0};
      for (int n = 0; n < 2; n++) begin
         step();
         check("R7 applied after sync", ch_s(0), mix_ref(nv, n), TOL);
      end

      // R11: channel 1 programmed alone; sync realigns both
      prog(1, VEC[3]);
      sync_pulse();
      for (int n = 0; n < 3; n++) begin
         step();
         check("R11 channel 0 untouched", ch_s(0), mix_ref(nv, n), TOL);
         check("R11 channel 1 own settings", ch_s(1), mix_ref(VEC[3], n), TOL);
      end

      // R5: source codes
      ext_smp = {16'hBEEF, 16'h1234};
      wr(0, 4, 32'd2);
      step();
      check("R5 stream source", ch_u(0), 16'h1234, 0);
      wr(0, 4, 32'd5);
      step();
      check("R5 unused code 5", ch_u(0), 0, 0);
      wr(0, 4, 32'd1);
      step();
      check("R5 unused code 1", ch_u(0), 0, 0);
      wr(0, 4, 32'd11);
      step();
      a = ch_u(0);
      step();
      check("R6 ramp step", ch_u(0), (a + 1) & 16'hFFFF, 0);

      // R9: tone path absent
      wr(0, 4, 32'd0);
      dds_absent = 1'b1;
      step();
      check("R9 tone silenced ch0", ch_u(0), 0, 0);
      check("R9 tone silenced ch1", ch_u(1), 0, 0);
      wr(0, 4, 32'd2);
      step();
      check("R9 stream unaffected", ch_u(0), 16'h1234, 0);
      dds_absent = 1'b0;

      // R8: core hold, writes still accepted
      @(negedge clk); core_run = 1'b0;
      prog(0, VEC[0]);
      wr(0, 4, 32'd0);
      sync_pulse();
      step();
      check("R8 held output", ch_u(0) + ch_u(1), 0, 0);
      check("R8 held valid", int'(smp_valid), 0, 0);
      @(negedge clk); core_run = 1'b1;
      for (int n = 0; n < 3; n++) begin
         step();
         check("R8 writes kept through hold", ch_s(0), mix_ref(VEC[0], n), TOL);
      end

      // R6: ramp wrap
      @(negedge clk); core_run = 1'b0;
      wr(0, 4, 32'd11);
      @(negedge clk); core_run = 1'b1;
      @(negedge clk); smp_en = 1'b1;
      repeat (65536) @(posedge clk);
      @(negedge clk);
      check("R6 ramp top", ch_u(0), 16'hFFFF, 0);
      @(negedge clk);
      check("R6 ramp wrap", ch_u(0), 0, 0);
      smp_en = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule